// File: doc/BRIEF.md
# Dual-Port Numerically Controlled Counter

This block is a per-core counter/timer that can drive or sense any of 64 I/O pins, which are split into two 32-bit ports. A single control word picks an operating mode, two 6-bit pin numbers (called A and B) and a tap for a synthesizable stand-in PLL. A 32-bit frequency word is added into a 33-bit phase register to produce NCO square waves, carry-based duty-cycle pulses and PLL-style clocks. In the input-sensing modes the same addition is gated by the levels, edges or a small logic function of the selected pins.

Software writes the control, frequency and phase words through three separate write strobes that share one data bus. The pin output vector goes to the pin multiplexing logic, which is outside this block. The phase register is visible at a port. The PLL stand-in runs on its own clock.

Top module: `dual_port_nco_counter`

## Requirements
- R1: After reset, the phase output, all 64 pin outputs and the PLL output are 0, and the mode is 00000.
- R2: Pin A is control bits [5:0] and pin B is control bits [14:9]. The top bit of each 6-bit pin number selects the port: 0 selects `pin_in`/`pin_out` bits [31:0] and 1 selects bits [63:32]. The low 5 bits pick the bit within that port. A port that neither pin selects has all of its outputs at 0.
- R3: The mode is control bits [30:26]. In mode 00000 the phase register holds its value and all pin outputs are 0.
- R4: In mode 00100, pin A outputs phase bit 31. In mode 00101, pin A outputs phase bit 31 and pin B outputs its inverse. When both pins fall in the same port, their drives are ORed.
- R5: In mode 00110, pin A outputs the carry held in phase bit 32. In mode 00111, pin B also outputs the inverse of that carry.
- R6: On each clock edge where the mode's condition is true, the phase becomes {carry, sum} of phase[31:0] + frequency. Modes 00001 through 00111 have an always-true condition. A phase write takes priority over accumulation and loads {0, wdata}.
- R7: A control or frequency write takes effect at the clock edge where it is written. The accumulation on that same edge still uses the previous value.
- R8: A 36-bit accumulator clocked by `pll_clk` adds the frequency only in modes 00001 through 00011. `pll_o` is accumulator bit 28 + (7 − control[25:23]). Mode 00010 drives pin A with `pll_o`. Mode 00011 also drives pin B with its inverse.
- R9: On every clock, the input delay bit 0 samples the level of pin A. Bit 1 samples the level of pin B when control bit 30 is set; otherwise it takes the old bit 0. Conditions use these sampled bits.
- R10: Modes 0100x, 0101x, 0110x and 0111x accumulate on sampled A high, A low, A rising edge and A falling edge respectively. All pin outputs are 0 in modes 01000 through 11111.
- R11: In modes 1xxxx, accumulation happens when mode bit {B,A} is 1, where the index is formed from sampled bit 1 and bit 0. Mode 10000 therefore never accumulates and mode 11111 always does. Second-port pins work as sensed inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pll_clk | input | 1 | Clock for the PLL stand-in accumulator |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Load the control word from `wdata` |
| frq_we | input | 1 | Load the frequency word from `wdata` |
| phs_we | input | 1 | Load the phase register from `wdata` |
| wdata | input | 32 | Shared write data |
| pin_in | input | 64 | Pin levels, first port in [31:0] and second port in [63:32] |
| pin_out | output | 64 | Pin drives, laid out the same way as `pin_in` |
| phase_o | output | 33 | Phase register, with the carry in bit 32 |
| pll_o | output | 1 | Selected PLL tap |

## Verification
The hardest state to reach is an input-sensing mode whose outcome depends on the two-cycle history held in the delay register. This matters most in the 1xxxx modes, where bit 1 is pin B rather than the old pin A. The stimulus starts each of these scenarios from reset with every pin low, so the delay history is known. Pin levels then change one per cycle at the falling edge, and a bench model of the delay register and gating condition predicts the phase after each edge. Second-port pins are used for A or B in these runs.

// File: rtl/ncocnt_pkg.sv
package ncocnt_pkg;

    typedef logic [4:0] mode_t;

    localparam mode_t M_OFF     = 5'b00000;
    localparam mode_t M_PLL_SE  = 5'b00010;
    localparam mode_t M_PLL_DF  = 5'b00011;
    localparam mode_t M_NCO_SE  = 5'b00100;
    localparam mode_t M_NCO_DF  = 5'b00101;
    localparam mode_t M_DUTY_SE = 5'b00110;
    localparam mode_t M_DUTY_DF = 5'b00111;

    typedef struct packed {
        logic a;
        logic b;
    } pin_drive_t;

    // Accumulation gate; d[0] is sampled A, d[1] is sampled B or old A.
    function automatic logic accum_cond(mode_t m, logic [1:0] d);
        logic c;
        if (m[4]) begin
            c = m[d];
        end else if (m[3]) begin
            case (m[2:1])
                2'b00:   c = d[0];
                2'b01:   c = !d[0];
                2'b10:   c = d[0] && !d[1];
                default: c = !d[0] && d[1];
            endcase
        end else begin
            c = (m != M_OFF);
        end
        return c;
    endfunction

    function automatic logic pll_enabled(mode_t m);
        return (m[4:2] == 3'b000) && (m[1:0] != 2'b00);
    endfunction

    function automatic pin_drive_t drive_levels(mode_t m, logic msb,
                                                logic carry, logic pll);
        pin_drive_t r;
        r = '0;
        case (m)
            M_PLL_SE:  r.a = pll;
            M_PLL_DF:  begin r.a = pll;   r.b = !pll;   end
            M_NCO_SE:  r.a = msb;
            M_NCO_DF:  begin r.a = msb;   r.b = !msb;   end
            M_DUTY_SE: r.a = carry;
            M_DUTY_DF: begin r.a = carry; r.b = !carry; end
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ncocnt_pin_route.sv
module ncocnt_pin_route #(
    parameter int PORT_W = 32,
    parameter int PORTS  = 2,
    localparam int TOTAL_W = PORT_W * PORTS,
    localparam int SEL_W   = $clog2(TOTAL_W)
) (
    input  logic [SEL_W-1:0]   sel_a,
    input  logic [SEL_W-1:0]   sel_b,
    input  logic               drv_a,
    input  logic               drv_b,
    input  logic [TOTAL_W-1:0] pin_in,
    output logic [TOTAL_W-1:0] pin_out,
    output logic               lvl_a,
    output logic               lvl_b
);
    localparam int LOW_W  = $clog2(PORT_W);
    localparam int PIDX_W = SEL_W - LOW_W;

    assign lvl_a = pin_in[sel_a];
    assign lvl_b = pin_in[sel_b];

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic              hit_a, hit_b;
        logic [PORT_W-1:0] mask_a, mask_b;
        assign hit_a  = (sel_a[SEL_W-1:LOW_W] == PIDX_W'(p));
        assign hit_b  = (sel_b[SEL_W-1:LOW_W] == PIDX_W'(p));
        assign mask_a = hit_a ? ({{(PORT_W-1){1'b0}}, drv_a} << sel_a[LOW_W-1:0]) : '0;
        assign mask_b = hit_b ? ({{(PORT_W-1){1'b0}}, drv_b} << sel_b[LOW_W-1:0]) : '0;
        assign pin_out[p*PORT_W +: PORT_W] = mask_a | mask_b;
    end

endmodule

// File: rtl/ncocnt_fake_pll.sv
module ncocnt_fake_pll #(
    parameter int ACC_W = 36,
    parameter int FRQ_W = 32,
    parameter int TAP_N = 8,
    localparam int TAP_W = $clog2(TAP_N)
) (
    input  logic             clk_pll,
    input  logic             rst_n,
    input  logic             en,
    input  logic [FRQ_W-1:0] frq,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             pll_o
);
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [TAP_N-1:0] taps;

    always_comb begin
        acc_d = acc_q;
        if (en) acc_d = acc_q + {{(ACC_W-FRQ_W){1'b0}}, frq};
    end

    always_ff @(posedge clk_pll) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign taps  = acc_q[ACC_W-1 -: TAP_N];
    assign pll_o = taps[~tap_sel];

    // R8: accumulator frozen outside the PLL modes
    p_pll_hold_r8: assert property (@(posedge clk_pll) disable iff (!rst_n)
        !en |=> $stable(acc_q));

endmodule

// File: rtl/dual_port_nco_counter.sv
module dual_port_nco_counter
    import ncocnt_pkg::*;
#(
    parameter int PORT_W = 32,
    parameter int PORTS  = 2,
    parameter int DATA_W = 32,
    parameter int PLL_W  = 36,
    parameter int TAP_N  = 8,
    localparam int TOTAL_W = PORT_W * PORTS,
    localparam int SEL_W   = $clog2(TOTAL_W),
    localparam int TAP_W   = $clog2(TAP_N)
) (
    input  logic               clk,
    input  logic               pll_clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic               frq_we,
    input  logic               phs_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [TOTAL_W-1:0] pin_in,
    output logic [TOTAL_W-1:0] pin_out,
    output logic [DATA_W:0]    phase_o,
    output logic               pll_o
);
    // control word field positions
    localparam int MODE_LSB = 26;
    localparam int TAP_LSB  = 23;
    localparam int PB_LSB   = 9;
    localparam int PA_LSB   = 0;

    typedef struct packed {
        mode_t            mode;
        logic [TAP_W-1:0] tap;
        logic [SEL_W-1:0] pin_a;
        logic [SEL_W-1:0] pin_b;
        logic [DATA_W-1:0] frq;
        logic [DATA_W:0]  phs;
        logic [1:0]       dly;
    } state_t;

    state_t     st_d, st_q;
    pin_drive_t drv;
    logic       lvl_a, lvl_b, pll_w, go;
    logic [DATA_W:0] sum;
    logic       unused_ctrl_bits;

    assign unused_ctrl_bits = ^{wdata[31], wdata[22:15], wdata[8:6]};

    ncocnt_fake_pll #(.ACC_W(PLL_W), .FRQ_W(DATA_W), .TAP_N(TAP_N)) u_pll (
        .clk_pll (pll_clk),
        .rst_n   (rst_n),
        .en      (pll_enabled(st_q.mode)),
        .frq     (st_q.frq),
        .tap_sel (st_q.tap),
        .pll_o   (pll_w)
    );

    ncocnt_pin_route #(.PORT_W(PORT_W), .PORTS(PORTS)) u_route (
        .sel_a   (st_q.pin_a),
        .sel_b   (st_q.pin_b),
        .drv_a   (drv.a),
        .drv_b   (drv.b),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .lvl_a   (lvl_a),
        .lvl_b   (lvl_b)
    );

    always_comb begin
        st_d = st_q;
        drv  = drive_levels(st_q.mode, st_q.phs[DATA_W-1], st_q.phs[DATA_W], pll_w);
        go   = accum_cond(st_q.mode, st_q.dly);
        sum  = {1'b0, st_q.phs[DATA_W-1:0]} + {1'b0, st_q.frq};

        if (phs_we)  st_d.phs = {1'b0, wdata};
        else if (go) st_d.phs = sum;

        if (frq_we) st_d.frq = wdata;
        if (ctrl_we) begin
            st_d.mode  = wdata[MODE_LSB +: 5];
            st_d.tap   = wdata[TAP_LSB +: TAP_W];
            st_d.pin_a = wdata[PA_LSB +: SEL_W];
            st_d.pin_b = wdata[PB_LSB +: SEL_W];
        end

        st_d.dly = {st_q.mode[4] ? lvl_b : st_q.dly[0], lvl_a};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phs;
    assign pll_o   = pll_w;

    // R3: disabled counter keeps its phase and drives nothing
    p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_OFF && !phs_we) |=> $stable(phase_o));
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_OFF) |-> (pin_out == '0));
    // R6: phase write wins over accumulation
    p_phs_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phs_we |=> (phase_o == {1'b0, $past(wdata)}));
    // R2: second port stays idle when no pin points at it
    p_idle_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pin_a[SEL_W-1] && !st_q.pin_b[SEL_W-1]) |-> (pin_out[TOTAL_W-1:PORT_W] == '0));
    // R4: differential NCO on distinct pins drives exactly one of them
    p_diff_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_NCO_DF && st_q.pin_a != st_q.pin_b) |-> ($countones(pin_out) == 1));
    // R10: sensing modes drive no pins
    p_input_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode[4:3] != 2'b00) |-> (pin_out == '0));

endmodule

// File: tb/dual_port_nco_counter_bench.sv
module dual_port_nco_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0, frq_we = 1'b0, phs_we = 1'b0;
    logic [31:0] wdata = '0;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out;
    logic [32:0] phase_o;
    logic        pll_o;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    dual_port_nco_counter u_dual_port_nco_counter (
        .clk(clk), .pll_clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .frq_we(frq_we), .phs_we(phs_we),
        .wdata(wdata), .pin_in(pin_in),
        .pin_out(pin_out), .phase_o(phase_o), .pll_o(pll_o)
    );

    // bench-side model of the input path
    logic [4:0]  m_mode;
    logic [5:0]  m_pa, m_pb;
    logic [1:0]  m_dly;
    logic [32:0] m_phs;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [4:0] mode, input logic [2:0] tap,
                                            input logic [5:0] pa, input logic [5:0] pb);
        return {1'b0, mode, tap, 8'h00, pb, 3'b000, pa};
    endfunction

    // which: 0 control, 1 frequency, 2 phase; returns at the falling edge after the write
    task automatic wr(input int which, input logic [31:0] d);
        @(negedge clk);
        ctrl_we = (which == 0);
        frq_we  = (which == 1);
        phs_we  = (which == 2);
        wdata   = d;
        @(negedge clk);
        ctrl_we = 1'b0; frq_we = 1'b0; phs_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_in = '0;
        ctrl_we = 1'b0; frq_we = 1'b0; phs_we = 1'b0; wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic m_cond(input logic [4:0] m, input logic [1:0] d);
        if (m[4]) return m[d];
        case (m[2:1])
            2'b00:   return d[0];
            2'b01:   return !d[0];
            2'b10:   return d[0] && !d[1];
            default: return !d[0] && d[1];
        endcase
    endfunction

    task automatic setup_input(input logic [4:0] mode, input logic [5:0] pa, input logic [5:0] pb);
        do_reset();
        wr(1, 32'd1);
        wr(0, mk_ctrl(mode, 3'd0, pa, pb));
        m_mode = mode; m_pa = pa; m_pb = pb; m_dly = 2'b00; m_phs = '0;
    endtask

    task automatic step(input string req, input logic a, input logic b);
        logic [63:0] v;
        v = '0;
        v[m_pa] = a;
        v[m_pb] = b;
        pin_in = v;
        @(negedge clk);
        if (m_cond(m_mode, m_dly)) m_phs = m_phs + 33'd1;
        m_dly = {m_mode[4] ? b : m_dly[0], a};
        chk(req, {31'b0, phase_o}, {31'b0, m_phs});
        chk("R10 outputs quiet", pin_out, 64'h0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 phase", {31'b0, phase_o}, 64'h0);
        chk("R1 pins", pin_out, 64'h0);
        chk("R1 pll", {63'b0, pll_o}, 64'h0);
    endtask

    task automatic t_off();
        do_reset();
        wr(1, 32'd5);
        wr(2, 32'd100);
        repeat (3) @(negedge clk);
        chk("R3 phase held", {31'b0, phase_o}, 64'd100);
        chk("R3 pins zero", pin_out, 64'h0);
    endtask

    task automatic t_nco();
        do_reset();
        wr(0, mk_ctrl(5'b00100, 3'd0, 6'd3, 6'd0));
        wr(2, 32'h8000_0000);
        chk("R4 single high", pin_out, 64'h1 << 3);
        wr(2, 32'h0);
        chk("R4 single low", pin_out, 64'h0);
        wr(0, mk_ctrl(5'b00101, 3'd0, 6'd3, 6'd40));
        wr(2, 32'h8000_0000);
        chk("R4 diff A side", pin_out, 64'h1 << 3);
        wr(2, 32'h0);
        chk("R2 R4 diff B on second port", pin_out, 64'h1 << 40);
        wr(0, mk_ctrl(5'b00101, 3'd0, 6'd5, 6'd7));
        @(negedge clk);
        chk("R2 R4 same port, other port zero", pin_out, 64'h1 << 7);
        wr(0, mk_ctrl(5'b00101, 3'd0, 6'd9, 6'd9));
        wr(2, 32'h8000_0000);
        chk("R4 OR on shared pin", pin_out, 64'h1 << 9);
        wr(2, 32'h0);
        chk("R4 OR on shared pin low phase", pin_out, 64'h1 << 9);
    endtask

    task automatic t_duty();
        do_reset();
        wr(1, 32'h8000_0000);
        wr(0, mk_ctrl(5'b00111, 3'd0, 6'd33, 6'd2));
        wr(2, 32'h8000_0000);
        chk("R6 load", {31'b0, phase_o}, 64'h0_8000_0000);
        chk("R5 no carry", pin_out, 64'h1 << 2);
        @(negedge clk);
        chk("R6 carry set", {31'b0, phase_o}, 64'h1_0000_0000);
        chk("R5 carry pulse", pin_out, 64'h1 << 33);
        @(negedge clk);
        chk("R5 carry cleared", pin_out, 64'h1 << 2);
    endtask

    task automatic t_accum();
        do_reset();
        wr(1, 32'd3);
        wr(0, mk_ctrl(5'b00100, 3'd0, 6'd0, 6'd0));
        wr(2, 32'd10);
        repeat (4) @(negedge clk);
        chk("R6 four adds", {31'b0, phase_o}, 64'd22);
        wr(2, 32'hFFFF_FFFE);
        @(negedge clk);
        chk("R6 wrap carry", {31'b0, phase_o}, 64'h1_0000_0001);
        @(negedge clk);
        chk("R6 carry drops", {31'b0, phase_o}, 64'h0_0000_0004);
    endtask

    task automatic t_ctrl_timing();
        do_reset();
        wr(1, 32'd1);
        wr(2, 32'd0);
        wr(0, mk_ctrl(5'b00100, 3'd0, 6'd0, 6'd0));
        chk("R7 write edge uses old mode", {31'b0, phase_o}, 64'd0);
        @(negedge clk);
        chk("R7 new mode next edge", {31'b0, phase_o}, 64'd1);
        wr(1, 32'd10);
        chk("R7 frq write edge uses old frq", {31'b0, phase_o}, 64'd3);
        @(negedge clk);
        chk("R7 new frq next edge", {31'b0, phase_o}, 64'd13);
    endtask

    task automatic t_pll(input logic [4:0] mode, input logic [2:0] tap,
                         input logic [5:0] pa, input logic [5:0] pb);
        logic [35:0] acc;
        logic        e;
        do_reset();
        wr(1, 32'h1000_0000);
        wr(0, mk_ctrl(mode, tap, pa, pb));
        acc = '0;
        chk("R8 idle before first add", {63'b0, pll_o}, 64'h0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            acc = acc + 36'h1000_0000;
            e = acc[28 + (7 - tap)];
            chk("R8 tap", {63'b0, pll_o}, {63'b0, e});
            if (mode == 5'b00011)
                chk("R8 pins", pin_out, ({63'b0, e} << pa) | ({63'b0, !e} << pb));
            else
                chk("R8 pin", pin_out, {63'b0, e} << pa);
        end
    endtask

    task automatic t_input_level();
        setup_input(5'b01000, 6'd37, 6'd0);
        step("R9 R10 level high", 1'b1, 1'b0);
        step("R9 R10 level high", 1'b1, 1'b0);
        step("R9 R10 level high", 1'b1, 1'b0);
        step("R9 R10 level high", 1'b0, 1'b0);
        step("R9 R10 level high", 1'b0, 1'b0);
        setup_input(5'b01010, 6'd4, 6'd0);
        step("R10 level low", 1'b1, 1'b0);
        step("R10 level low", 1'b1, 1'b0);
        step("R10 level low", 1'b0, 1'b0);
        step("R10 level low", 1'b0, 1'b0);
    endtask

    task automatic t_input_edge();
        setup_input(5'b01100, 6'd2, 6'd0);
        step("R10 rising", 1'b1, 1'b0);
        step("R10 rising", 1'b1, 1'b0);
        step("R10 rising", 1'b0, 1'b0);
        step("R10 rising", 1'b1, 1'b0);
        step("R10 rising", 1'b1, 1'b0);
        step("R10 rising", 1'b1, 1'b0);
        setup_input(5'b01110, 6'd50, 6'd0);
        step("R10 falling", 1'b1, 1'b0);
        step("R10 falling", 1'b0, 1'b0);
        step("R10 falling", 1'b0, 1'b0);
        step("R10 falling", 1'b0, 1'b0);
    endtask

    task automatic t_logic();
        setup_input(5'b10110, 6'd40, 6'd12);
        step("R11 xor", 1'b1, 1'b0);
        step("R11 xor", 1'b1, 1'b1);
        step("R11 xor", 1'b0, 1'b1);
        step("R11 xor", 1'b0, 1'b0);
        step("R11 xor", 1'b1, 1'b0);
        step("R11 xor", 1'b0, 1'b0);
        setup_input(5'b10000, 6'd63, 6'd32);
        step("R11 never", 1'b1, 1'b1);
        step("R11 never", 1'b1, 1'b0);
        step("R11 never", 1'b0, 1'b1);
        setup_input(5'b11000, 6'd1, 6'd45);
        step("R11 both high", 1'b1, 1'b1);
        step("R11 both high", 1'b1, 1'b1);
        step("R11 both high", 1'b0, 1'b1);
        step("R11 both high", 1'b1, 1'b1);
        setup_input(5'b11111, 6'd1, 6'd2);
        step("R11 always", 1'b0, 1'b0);
        step("R11 always", 1'b1, 1'b0);
        step("R11 always", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_off();
        t_nco();
        t_duty();
        t_accum();
        t_ctrl_timing();
        t_pll(5'b00010, 3'd7, 6'd2, 6'd0);
        t_pll(5'b00011, 3'd6, 6'd1, 6'd34);
        t_input_level();
        t_input_edge();
        t_logic();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule